// File: doc/BRIEF.md
# Package Low-Power State Sequencer

This block tracks the halt status of every core in a multi-core package and, from that status, moves the whole package between five power states. The states are running, package halt, stop-grant, halt-snoop and stop-grant-snoop. The package drops into halt only after every core has halted and the halt bus cycle has been seen. A single halted core leaves the package running.

A stop-clock request can be raised from running or from halt. A bus snoop can arrive in halt or in stop-grant. Each of these excursions goes back to the state it started from, and a single saved bit records whether that state was running or halt. Wake events end a halt and return the package to running. A configuration input chooses the extended (deeper) variant of the halt and stop-grant states. That choice is captured when the package leaves running and is held until it returns there. A resume strobe from the system-management handler can put the package straight back into halt.

All outputs come from registers, so every transition shows one clock after the input that caused it.

Top module: `lp_state_seq`

## Requirements
- R1: A synchronous active-high reset puts the package in running from any state, clears every halted flag and clears the extended flag. State encoding on `state_o` is: bit 0 running, bit 1 halt, bit 2 stop-grant, bit 3 halt-snoop, bit 4 stop-grant-snoop.
- R2: In running, and with no wake event, a halt request on a core sets that core's halted flag. The package stays in running while any flag is clear. A wake event in running clears all flags.
- R3: The package moves from running to halt only when every halted flag is already set and `halt_cycle_i` is high. With all flags set and no halt cycle, it stays in running.
- R4: In halt, any bit of `wake_i` returns the package to running and clears every halted flag. A wake event takes priority over a snoop and over a stop-clock request in the same cycle.
- R5: A high `stpclk_i` moves the package from running or from halt into stop-grant. When `stpclk_i` goes low in stop-grant, the package returns to the state it came from.
- R6: `snoop_i` moves the package from halt to halt-snoop and from stop-grant to stop-grant-snoop. `snoop_done_i` returns it to the originating halt or stop-grant state. In stop-grant, a snoop takes priority over a stop-clock release.
- R7: `ext_mode_o` is low in running. When the package leaves running, it takes the value of `ext_en_i`, and it holds that value through halt, stop-grant and snoop excursions until the package is back in running.
- R8: In running, with no wake and no stop-clock request, `smi_rsm_i` together with `rsm_halt_i` sends the package to halt and sets every halted flag. `smi_rsm_i` alone leaves the package in running.
- R9: `clk_run_o` is high in every state, including the low-power and snoop states.
- R10: `state_o` always has exactly one bit set.
- R11: The following inputs have no effect: wake events in stop-grant and in both snoop states, `stpclk_i` in both snoop states, and halt requests outside running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| core_halt_i | input | NUM_CORES | Per-core halt/MWAIT executed strobe |
| halt_cycle_i | input | 1 | Halt bus cycle generated |
| wake_i | input | WAKE_W | Wake events (INIT, INTR, NMI, SMI, bus interrupt) |
| smi_rsm_i | input | 1 | Return from system-management handler |
| rsm_halt_i | input | 1 | Resume destination is halt |
| stpclk_i | input | 1 | Stop-clock request level |
| snoop_i | input | 1 | Snoop event strobe |
| snoop_done_i | input | 1 | Snoop serviced strobe |
| ext_en_i | input | 1 | Enable extended low-power variants |
| state_o | output | 5 | One-hot package state |
| ext_mode_o | output | 1 | Extended variant active |
| core_halted_o | output | NUM_CORES | Per-core halted flags |
| clk_run_o | output | 1 | Bus clock running |

## Verification
Every result of this block (state, halted flags, extended flag) is due exactly one rising edge after the input that causes it. The bench drives inputs just after a falling edge, and the design samples them on the next rising edge. A behavioural model in the bench updates on that same rising edge, and all outputs are compared with the model at the following falling edge. The directed checks use the same timing: they read the outputs after exactly one edge, so a result that comes a cycle late or a cycle early fails that read.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
   localparam int NUM_STATES = 5;
   typedef enum logic [NUM_STATES-1:0] {
      ST_RUN  = 5'b00001,
      ST_HALT = 5'b00010,
      ST_STPG = 5'b00100,
      ST_HSNP = 5'b01000,
      ST_SSNP = 5'b10000
   } lp_state_e;
endpackage

// File: rtl/lp_halt_track.sv
module lp_halt_track #(
   parameter int NUM_CORES = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 track_en_i,
   input  logic                 clr_i,
   input  logic                 set_all_i,
   input  logic [NUM_CORES-1:0] req_i,
   output logic [NUM_CORES-1:0] halted_o,
   output logic                 all_halted_o
);
   generate
      if (NUM_CORES < 1) begin : g_bad_cores
         $error("NUM_CORES must be at least 1");
      end
   endgenerate

   logic [NUM_CORES-1:0] flag_q;

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      always_ff @(posedge clk_i) begin
         if (rst_i || clr_i)       flag_q[c] <= 1'b0;
         else if (set_all_i)       flag_q[c] <= 1'b1;
         else if (track_en_i && req_i[c]) flag_q[c] <= 1'b1;
      end
   end

   assign halted_o     = flag_q;
   assign all_halted_o = &flag_q;

   // R2: a flag never drops unless a clear was requested
   assert_flag_sticky_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      !clr_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
   // R11: requests outside tracking leave flags unchanged
   assert_req_ignored_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      (!track_en_i && !clr_i && !set_all_i) |=> $stable(flag_q));
endmodule

// File: rtl/lp_state_fsm.sv
module lp_state_fsm
   import lp_seq_pkg::*;
#(
   parameter int WAKE_W        = 5,
   parameter bit EXT_AT_ENTRY  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [WAKE_W-1:0] wake_i,
   input  logic              stpclk_i,
   input  logic              snoop_i,
   input  logic              snoop_done_i,
   input  logic              halt_cycle_i,
   input  logic              all_halted_i,
   input  logic              smi_rsm_i,
   input  logic              rsm_halt_i,
   input  logic              ext_en_i,
   output lp_state_e         state_o,
   output logic              ext_mode_o,
   output logic              track_en_o,
   output logic              clr_o,
   output logic              set_all_o
);
   generate
      if (WAKE_W < 1) begin : g_bad_wake
         $error("WAKE_W must be at least 1");
      end
   endgenerate

   lp_state_e state_q, state_d;
   logic      ret_halt_q, ret_halt_d;
   logic      ext_q;
   logic      any_wake;

   assign any_wake = |wake_i;

   always_comb begin
      state_d    = state_q;
      ret_halt_d = ret_halt_q;
      track_en_o = 1'b0;
      clr_o      = 1'b0;
      set_all_o  = 1'b0;
      unique case (state_q)
         ST_RUN: begin
            if (any_wake) begin
               clr_o = 1'b1;
            end else begin
               track_en_o = 1'b1;
               if (stpclk_i) begin
                  state_d    = ST_STPG;
                  ret_halt_d = 1'b0;
               end else if (smi_rsm_i && rsm_halt_i) begin
                  state_d   = ST_HALT;
                  set_all_o = 1'b1;
               end else if (all_halted_i && halt_cycle_i) begin
                  state_d = ST_HALT;
               end
            end
         end
         ST_HALT: begin
            if (any_wake) begin
               state_d = ST_RUN;
               clr_o   = 1'b1;
            end else if (stpclk_i) begin
               state_d    = ST_STPG;
               ret_halt_d = 1'b1;
            end else if (snoop_i) begin
               state_d = ST_HSNP;
            end
         end
         ST_STPG: begin
            if (snoop_i)        state_d = ST_SSNP;
            else if (!stpclk_i) state_d = ret_halt_q ? ST_HALT : ST_RUN;
         end
         ST_HSNP: if (snoop_done_i) state_d = ST_HALT;
         ST_SSNP: if (snoop_done_i) state_d = ST_STPG;
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q    <= ST_RUN;
         ret_halt_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         ret_halt_q <= ret_halt_d;
      end
   end

   generate
      if (EXT_AT_ENTRY) begin : g_ext_latch
         always_ff @(posedge clk_i) begin
            if (rst_i || state_d == ST_RUN) ext_q <= 1'b0;
            else if (state_q == ST_RUN)     ext_q <= ext_en_i;
         end
      end else begin : g_ext_live
         always_ff @(posedge clk_i) begin
            if (rst_i) ext_q <= 1'b0;
            else       ext_q <= ext_en_i && (state_d != ST_RUN);
         end
      end
   endgenerate

   assign state_o    = state_q;
   assign ext_mode_o = ext_q;

   assert_onehot_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(state_q) == 1);
   assert_no_early_halt_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_RUN && !all_halted_i && !(smi_rsm_i && rsm_halt_i)) |=> state_q != ST_HALT);
   assert_wake_exit_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_HALT && any_wake) |=> state_q == ST_RUN);
   assert_stpg_release_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_STPG && !stpclk_i && !snoop_i) |=> (state_q == ST_RUN || state_q == ST_HALT));
   assert_hsnp_return_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_HSNP && snoop_done_i) |=> state_q == ST_HALT);
   assert_ssnp_return_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_SSNP && snoop_done_i) |=> state_q == ST_STPG);
   assert_ext_run_low_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_RUN) |-> !ext_q);
   assert_snoop_hold_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      ((state_q == ST_HSNP || state_q == ST_SSNP) && !snoop_done_i) |=> $stable(state_q));
endmodule

// File: rtl/lp_state_seq.sv
module lp_state_seq
   import lp_seq_pkg::*;
#(
   parameter int NUM_CORES    = 2,
   parameter int WAKE_W       = 5,
   parameter bit EXT_AT_ENTRY = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic [NUM_CORES-1:0]  core_halt_i,
   input  logic                  halt_cycle_i,
   input  logic [WAKE_W-1:0]     wake_i,
   input  logic                  smi_rsm_i,
   input  logic                  rsm_halt_i,
   input  logic                  stpclk_i,
   input  logic                  snoop_i,
   input  logic                  snoop_done_i,
   input  logic                  ext_en_i,
   output logic [NUM_STATES-1:0] state_o,
   output logic                  ext_mode_o,
   output logic [NUM_CORES-1:0]  core_halted_o,
   output logic                  clk_run_o
);
   lp_state_e state;
   logic      track_en, clr, set_all, all_halted;

   lp_state_fsm #(
      .WAKE_W       (WAKE_W),
      .EXT_AT_ENTRY (EXT_AT_ENTRY)
   ) u_fsm (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .wake_i       (wake_i),
      .stpclk_i     (stpclk_i),
      .snoop_i      (snoop_i),
      .snoop_done_i (snoop_done_i),
      .halt_cycle_i (halt_cycle_i),
      .all_halted_i (all_halted),
      .smi_rsm_i    (smi_rsm_i),
      .rsm_halt_i   (rsm_halt_i),
      .ext_en_i     (ext_en_i),
      .state_o      (state),
      .ext_mode_o   (ext_mode_o),
      .track_en_o   (track_en),
      .clr_o        (clr),
      .set_all_o    (set_all)
   );

   lp_halt_track #(
      .NUM_CORES (NUM_CORES)
   ) u_track (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .track_en_i   (track_en),
      .clr_i        (clr),
      .set_all_i    (set_all),
      .req_i        (core_halt_i),
      .halted_o     (core_halted_o),
      .all_halted_o (all_halted)
   );

   assign state_o   = state;
   assign clk_run_o = |state;

   // R1: every state is left for running one edge after reset
   assert_reset_run_R1: assert property (@(posedge clk_i)
      $past(rst_i) |-> (state_o == 5'b00001 && core_halted_o == '0 && !ext_mode_o));
   // R9: bus clock indication stays up after reset
   assert_clk_run_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> clk_run_o);
endmodule

// File: tb/lp_state_seq_bench.sv
module lp_state_seq_bench;
   localparam int NC = 2;
   localparam int WW = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NC-1:0] core_halt = '0;
   logic          halt_cycle = 1'b0;
   logic [WW-1:0] wake = '0;
   logic          smi_rsm = 1'b0, rsm_halt = 1'b0;
   logic          stpclk = 1'b0, snoop = 1'b0, snoop_done = 1'b0, ext_en = 1'b0;
   logic [4:0]    state_o;
   logic          ext_mode_o, clk_run_o;
   logic [NC-1:0] halted_o;

   always #2 clk = ~clk;

   lp_state_seq u_lp_state_seq (
      .clk_i(clk), .rst_i(rst), .core_halt_i(core_halt), .halt_cycle_i(halt_cycle),
      .wake_i(wake), .smi_rsm_i(smi_rsm), .rsm_halt_i(rsm_halt), .stpclk_i(stpclk),
      .snoop_i(snoop), .snoop_done_i(snoop_done), .ext_en_i(ext_en),
      .state_o(state_o), .ext_mode_o(ext_mode_o), .core_halted_o(halted_o),
      .clk_run_o(clk_run_o));

   int    n_tests = 0, n_fail = 0;
   string cur_req = "R1";
   bit    model_on = 1'b0;

   // reference model: state index 0 run,1 halt,2 stop-grant,3 halt-snoop,4 sg-snoop
   int          ms = 0;
   bit          mret = 0, mext = 0;
   bit [NC-1:0] mh = '0;

   always @(posedge clk) begin
      int          ns;
      bit [NC-1:0] nh;
      bit          nret, nx;
      bit          w;
      ns = ms; nh = mh; nret = mret; nx = mext; w = (wake != 0);
      if (rst) begin
         ns = 0; nh = '0; nret = 0; nx = 0;
      end else if (ms == 0) begin
         if (w) nh = '0;
         else begin
            nh = mh | core_halt;
            if (stpclk) begin ns = 2; nret = 0; end
            else if (smi_rsm && rsm_halt) begin ns = 1; nh = '1; end
            else if (mh == '1 && halt_cycle) ns = 1;
            if (ns != 0) nx = ext_en;
         end
      end else if (ms == 1) begin
         if (w) begin ns = 0; nh = '0; end
         else if (stpclk) begin ns = 2; nret = 1; end
         else if (snoop) ns = 3;
      end else if (ms == 2) begin
         if (snoop) ns = 4;
         else if (!stpclk) ns = mret ? 1 : 0;
      end else if (ms == 3) begin
         if (snoop_done) ns = 1;
      end else begin
         if (snoop_done) ns = 2;
      end
      if (ns == 0) nx = 0;
      ms = ns; mh = nh; mret = nret; mext = nx;
      model_on = 1'b1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (model_on) begin
         check(state_o == 5'(1 << ms), cur_req, "state vs model", state_o, 1 << ms);
         check(halted_o == mh, cur_req, "halted vs model", halted_o, mh);
         check(ext_mode_o == mext, cur_req, "ext vs model", ext_mode_o, mext);
         check(clk_run_o == 1'b1, "R9", "clk_run", clk_run_o, 1);
         check($countones(state_o) == 1, "R10", "onehot", state_o, 0);
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic idle();
      core_halt = '0; halt_cycle = 0; wake = '0; smi_rsm = 0; rsm_halt = 0;
      snoop = 0; snoop_done = 0;
   endtask

   task automatic expect_st(input logic [4:0] exp, input string req);
      check(state_o == exp, req, "directed state", state_o, exp);
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk); cyc++;
         if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   initial begin
      cur_req = "R1 reset";
      tick(); tick(); tick();
      rst = 0;
      expect_st(5'b00001, "R1");
      check(halted_o == 0 && ext_mode_o == 0, "R1", "flags after reset", halted_o, 0);

      cur_req = "R2 one core";
      core_halt = 2'b01; tick(); idle(); tick();
      expect_st(5'b00001, "R2");
      check(halted_o == 2'b01, "R2", "single flag", halted_o, 1);

      cur_req = "R3 entry";
      core_halt = 2'b10; tick(); idle();
      tick(); expect_st(5'b00001, "R3");
      halt_cycle = 1; tick(); idle();
      expect_st(5'b00010, "R3");

      cur_req = "R6 halt snoop";
      snoop = 1; tick(); idle(); expect_st(5'b01000, "R6");
      cur_req = "R11 snoop ignores";
      stpclk = 1; wake = 5'b00100; tick(); idle(); stpclk = 0;
      expect_st(5'b01000, "R11");
      cur_req = "R6 done";
      snoop_done = 1; tick(); idle(); expect_st(5'b00010, "R6");

      cur_req = "R5 from halt";
      stpclk = 1; tick(); expect_st(5'b00100, "R5");
      snoop = 1; tick(); idle(); expect_st(5'b10000, "R6");
      snoop_done = 1; tick(); idle(); expect_st(5'b00100, "R6");
      stpclk = 0; tick(); expect_st(5'b00010, "R5");

      cur_req = "R4 wake beats snoop";
      wake = 5'b00001; snoop = 1; tick(); idle();
      expect_st(5'b00001, "R4");
      check(halted_o == 0, "R4", "flags cleared", halted_o, 0);

      cur_req = "R7 extended";
      ext_en = 1; core_halt = 2'b11; tick(); idle();
      halt_cycle = 1; tick(); idle();
      expect_st(5'b00010, "R7");
      check(ext_mode_o == 1, "R7", "ext set", ext_mode_o, 1);
      ext_en = 0; tick();
      check(ext_mode_o == 1, "R7", "ext held", ext_mode_o, 1);
      stpclk = 1; tick(); stpclk = 0; tick();
      check(ext_mode_o == 1, "R7", "ext held after sg", ext_mode_o, 1);
      wake = 5'b10000; tick(); idle();
      check(ext_mode_o == 0, "R7", "ext low in run", ext_mode_o, 0);

      cur_req = "R5 from run";
      stpclk = 1; tick(); expect_st(5'b00100, "R5");
      cur_req = "R11 wake in sg";
      wake = 5'b00010; tick(); idle(); expect_st(5'b00100, "R11");
      stpclk = 0; tick(); expect_st(5'b00001, "R5");

      cur_req = "R8 resume";
      smi_rsm = 1; tick(); idle(); expect_st(5'b00001, "R8");
      smi_rsm = 1; rsm_halt = 1; tick(); idle();
      expect_st(5'b00010, "R8");
      check(halted_o == 2'b11, "R8", "flags set", halted_o, 3);

      cur_req = "R11 halt req in halt";
      wake = 5'b01000; tick(); idle();
      stpclk = 1; tick(); core_halt = 2'b11; tick(); idle(); stpclk = 0; tick();
      check(halted_o == 0, "R11", "req ignored in sg", halted_o, 0);

      cur_req = "R1 reset from halt";
      smi_rsm = 1; rsm_halt = 1; tick(); idle();
      rst = 1; tick(); rst = 0;
      expect_st(5'b00001, "R1");
      check(halted_o == 0, "R1", "flags cleared", halted_o, 0);

      cur_req = "R10 random";
      for (int i = 0; i < 4000; i++) begin
         rst        = ($urandom_range(0, 299) == 0);
         core_halt  = NC'($urandom_range(0, 3));
         halt_cycle = ($urandom_range(0, 3) == 0);
         wake       = ($urandom_range(0, 15) == 0) ? WW'($urandom_range(1, 31)) : '0;
         smi_rsm    = ($urandom_range(0, 19) == 0);
         rsm_halt   = $urandom_range(0, 1);
         snoop      = ($urandom_range(0, 5) == 0);
         snoop_done = ($urandom_range(0, 3) == 0);
         ext_en     = $urandom_range(0, 1);
         if ($urandom_range(0, 9) == 0) stpclk = ~stpclk;
         tick();
      end
      idle(); rst = 0; tick(); tick();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule